// File: doc/BRIEF.md
# Packing Transmit Queue for a Serial Shifter

This block is a small transmit queue. A register-write port fills it, and a serial shift engine empties it one frame at a time. Frames are 4 to 16 bits wide, and the width is set on `frm_len`. Storage is a ring of byte slots, four by default.

When a frame fits in one byte (8 bits or less), the queue packs frames:
- A halfword write deposits two frames, and its low byte goes out first.
- A byte write deposits exactly one frame, so software can finish a run that has an odd number of frames.

When a frame is wider than 8 bits, every write becomes one frame that takes two byte slots.

The shift side sees the oldest frame on `pop_data` while `pop_valid` is high, and takes it with `pop_req`. Software writes only while `tx_empty` is high. `tx_empty` means at least half of the slots are free. A write that does not fit is discarded and sets a sticky overflow flag. `soft_clr` empties the queue and clears that flag.

Occupancy is kept by a four-state machine beside a byte counter. The states are:
- `OCC_EMPTY`: no bytes held.
- `OCC_ROOMY`: at least one byte held, and at least half of the slots free.
- `OCC_TIGHT`: less than half free, but not full.
- `OCC_FULL`: every slot held.

Every cycle the next state is chosen from the next byte count. The transitions are:
- Fill-up (`OCC_EMPTY`→`OCC_ROOMY`/`OCC_TIGHT`/`OCC_FULL`).
- Crowding (`OCC_ROOMY`→`OCC_TIGHT`/`OCC_FULL`, `OCC_TIGHT`→`OCC_FULL`).
- Easing (`OCC_FULL`/`OCC_TIGHT`→`OCC_ROOMY`, `OCC_FULL`→`OCC_TIGHT`).
- Drain-out (any state→`OCC_EMPTY`). Drain-out is also the only transition that `soft_clr` and reset take.
- Hold (no change).

Top module: `spi_tx_pack_fifo`

## Requirements
- R1: After reset, `fill_bytes` is 0, `tx_empty` is 1, `pop_valid` is 0 and `ovf` is 0.
- R2: With `frm_len` ≤ 8, a halfword write (`wr_half`=1) stores two frames: `wr_data[7:0]` is popped first and `wr_data[15:8]` second (0x040A pops 0x0A then 0x04), and `fill_bytes` rises by 2.
- R3: With `frm_len` ≤ 8, a byte write (`wr_half`=0) stores exactly one frame, `wr_data[7:0]`, and `fill_bytes` rises by 1.
- R4: With `frm_len` > 8, every write stores one frame taking two byte slots. A halfword write stores `wr_data[15:0]`; a byte write stores `wr_data[7:0]` with a zero upper byte.
- R5: `pop_data` is the oldest frame, zero-extended to 16 bits, with every bit at position `frm_len` and above cleared.
- R6: `tx_empty` is 1 exactly when `fill_bytes` ≤ half the byte capacity (2 by default).
- R7: A write needing more free bytes than are available is discarded and leaves the held frames unchanged. It sets `ovf`, which stays set until `soft_clr`.
- R8: `soft_clr` empties the queue and clears `ovf`, taking effect at the next clock edge.
- R9: `pop_req` while `pop_valid` is 0 has no effect: `fill_bytes` and the frame order are unchanged.
- R10: `pop_valid` is 1 when `fill_bytes` ≥ 1 with `frm_len` ≤ 8, and when `fill_bytes` ≥ 2 with `frm_len` > 8.
- R11: A write and a pop in the same cycle both take effect. The free-space test for the write uses the byte count before that pop.
- R12: `fill_bytes` reports the number of byte slots held, one clock after the write or pop that changed it, and never exceeds the capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Synchronous flush; clears overflow |
| frm_len | input | 5 | Frame width in bits, 4 to 16 |
| wr_en | input | 1 | Write strobe from the register port |
| wr_half | input | 1 | 1 = halfword access, 0 = byte access |
| wr_data | input | 16 | Write data |
| pop_req | input | 1 | Shift engine takes the head frame |
| pop_data | output | 16 | Oldest frame, zero-extended |
| pop_valid | output | 1 | A whole frame is available |
| tx_empty | output | 1 | At least half of the slots free |
| fill_bytes | output | 3 | Byte slots held |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The bench targets the following corner cases, each paired with the failure it catches:
- Byte order of a packed halfword: a swapped unpacker would emit 0x04 before 0x0A.
- An odd run finished with a byte write: a design that always pushed two bytes would emit a stray extra frame or mis-align every later frame.
- Writes arriving when the queue is nearly or completely full, including one that coincides with a pop: a design that checked space after the pop would accept a frame the requirement says to drop, and a design that dropped silently would leave `ovf` low.
- A single byte left behind after `frm_len` is widened: a design gating `pop_valid` on "not empty" alone would hand the shifter half a frame.
- Masking with short frame widths: unmasked data would leak bits above `frm_len`.

// File: rtl/spi_txpk_pkg.sv
package spi_txpk_pkg;

    localparam int unsigned BYTE_W       = 8;
    localparam int unsigned NARROW_LIMIT = 8;

    typedef enum logic [1:0] {
        OCC_EMPTY,
        OCC_ROOMY,
        OCC_TIGHT,
        OCC_FULL
    } occ_state_t;

    typedef struct packed {
        logic [1:0]        n;
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
    } byte_pair_t;

endpackage

// File: rtl/txpk_unpack.sv
module txpk_unpack
    import spi_txpk_pkg::*;
(
    input  logic             narrow,
    input  logic             wr_half,
    input  logic [15:0]      wr_data,
    output byte_pair_t       pkt
);

    always_comb begin
        pkt.lo = wr_data[BYTE_W-1:0];
        pkt.hi = '0;
        pkt.n  = 2'd2;
        if (narrow) begin
            if (wr_half) begin
                pkt.hi = wr_data[15:BYTE_W];
                pkt.n  = 2'd2;
            end else begin
                pkt.n  = 2'd1;
            end
        end else begin
            if (wr_half) begin
                pkt.hi = wr_data[15:BYTE_W];
            end
        end
    end

endmodule

// File: rtl/txpk_bytestore.sv
module txpk_bytestore
    import spi_txpk_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push_en,
    input  byte_pair_t        pkt,
    input  logic              pop_en,
    input  logic              pop_two,
    output logic [BYTE_W-1:0] head_lo,
    output logic [BYTE_W-1:0] head_hi
);

    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] ONE_P = AW'(1);
    localparam logic [AW-1:0] TWO_P = AW'(2);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr_q;
    logic [AW-1:0]     rptr_q;
    logic [AW-1:0]     wstep;
    logic [AW-1:0]     rstep;

    initial begin
        depth_pow2_chk: assert ((DEPTH >= 2) && ((DEPTH & (DEPTH - 1)) == 0));
    end

    always_comb begin
        wstep = (pkt.n == 2'd2) ? TWO_P : ONE_P;
        rstep = pop_two ? TWO_P : ONE_P;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else if (flush) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            if (push_en) wptr_q <= wptr_q + wstep;
            if (pop_en)  rptr_q <= rptr_q + rstep;
        end
    end

    always_ff @(posedge clk) begin
        if (push_en && !flush) begin
            mem[wptr_q] <= pkt.lo;
            if (pkt.n == 2'd2) mem[wptr_q + ONE_P] <= pkt.hi;
        end
    end

    always_comb begin
        head_lo = mem[rptr_q];
        head_hi = mem[rptr_q + ONE_P];
    end

    // R3
    push_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |-> (pkt.n != 2'd0));

endmodule

// File: rtl/txpk_occ_fsm.sv
module txpk_occ_fsm
    import spi_txpk_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_clr,
    input  logic          wr_en,
    input  logic [1:0]    push_n,
    input  logic          pop_req,
    input  logic          pop_two,
    output logic          push_ok,
    output logic          pop_ok,
    output logic [CW-1:0] fill,
    output logic          tx_empty,
    output logic          pop_valid,
    output logic          ovf
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_C  = CW'(DEPTH / 2);
    localparam logic [CW-1:0] ONE_C   = CW'(1);
    localparam logic [CW-1:0] TWO_C   = CW'(2);

    occ_state_t    state_q;
    occ_state_t    state_nx;
    logic [CW-1:0] fill_q;
    logic [CW-1:0] fill_nx;
    logic [CW-1:0] free_b;
    logic [CW-1:0] need_b;
    logic [CW-1:0] push_amt;
    logic [CW-1:0] pop_amt;
    logic          narrow_ready;
    logic          ovf_q;

    // Space and pop decisions
    always_comb begin
        free_b   = DEPTH_C - fill_q;
        need_b   = pop_two ? TWO_C : ONE_C;
        push_ok  = wr_en && (free_b >= CW'(push_n));
        pop_ok   = pop_req && pop_valid;
        push_amt = push_ok ? CW'(push_n) : '0;
        pop_amt  = pop_ok ? need_b : '0;
        fill_nx  = fill_q + push_amt - pop_amt;
    end

    // Next state from next byte count
    always_comb begin
        if (fill_nx == '0)         state_nx = OCC_EMPTY;
        else if (fill_nx <= HALF_C) state_nx = OCC_ROOMY;
        else if (fill_nx < DEPTH_C) state_nx = OCC_TIGHT;
        else                        state_nx = OCC_FULL;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            fill_q  <= '0;
            ovf_q   <= 1'b0;
        end else if (soft_clr) begin
            state_q <= OCC_EMPTY;
            fill_q  <= '0;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_nx;
            fill_q  <= fill_nx;
            if (wr_en && !push_ok) ovf_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        tx_empty     = 1'b0;
        narrow_ready = 1'b0;
        unique case (state_q)
            OCC_EMPTY: begin
                tx_empty = 1'b1;
            end
            OCC_ROOMY: begin
                tx_empty     = 1'b1;
                narrow_ready = 1'b1;
            end
            OCC_TIGHT: begin
                narrow_ready = 1'b1;
            end
            OCC_FULL: begin
                narrow_ready = 1'b1;
            end
            default: begin
                tx_empty = 1'b0;
            end
        endcase
        pop_valid = pop_two ? (fill_q >= TWO_C) : narrow_ready;
        fill      = fill_q;
        ovf       = ovf_q;
    end

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !soft_clr) |=> ovf);

    // R7
    drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !push_ok && !pop_ok && !soft_clr) |=> $stable(fill));

    // R8
    soft_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> ((fill == '0) && !ovf));

    // R9
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && (fill == '0) && !wr_en && !soft_clr) |=> (fill == '0));

    // R6
    tx_empty_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty == (fill <= HALF_C));

    // R12
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= DEPTH_C);

endmodule

// File: rtl/spi_tx_pack_fifo.sv
module spi_tx_pack_fifo
    import spi_txpk_pkg::*;
#(
    parameter int unsigned DEPTH_BYTES = 4,
    parameter int unsigned LEN_W       = 5
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 soft_clr,
    input  logic [LEN_W-1:0]                     frm_len,
    input  logic                                 wr_en,
    input  logic                                 wr_half,
    input  logic [15:0]                          wr_data,
    input  logic                                 pop_req,
    output logic [15:0]                          pop_data,
    output logic                                 pop_valid,
    output logic                                 tx_empty,
    output logic [$clog2(DEPTH_BYTES + 1)-1:0]   fill_bytes,
    output logic                                 ovf
);

    localparam int unsigned CW     = $clog2(DEPTH_BYTES + 1);
    localparam int unsigned FRAME_W = 2 * BYTE_W;

    logic              narrow;
    logic              push_ok;
    logic              pop_ok;
    byte_pair_t        pkt;
    logic [BYTE_W-1:0] head_lo;
    logic [BYTE_W-1:0] head_hi;
    logic [FRAME_W-1:0] len_mask;
    logic [FRAME_W-1:0] raw_frame;

    always_comb begin
        narrow = (frm_len <= LEN_W'(NARROW_LIMIT));
        if (frm_len >= LEN_W'(FRAME_W)) len_mask = '1;
        else                            len_mask = (FRAME_W'(1) << frm_len) - FRAME_W'(1);
        raw_frame = {(narrow ? {BYTE_W{1'b0}} : head_hi), head_lo};
        pop_data  = raw_frame & len_mask;
    end

    txpk_unpack u_unpack (
        .narrow  (narrow),
        .wr_half (wr_half),
        .wr_data (wr_data),
        .pkt     (pkt)
    );

    txpk_occ_fsm #(
        .DEPTH (DEPTH_BYTES),
        .CW    (CW)
    ) u_occ (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_clr  (soft_clr),
        .wr_en     (wr_en),
        .push_n    (pkt.n),
        .pop_req   (pop_req),
        .pop_two   (!narrow),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok),
        .fill      (fill_bytes),
        .tx_empty  (tx_empty),
        .pop_valid (pop_valid),
        .ovf       (ovf)
    );

    txpk_bytestore #(
        .DEPTH (DEPTH_BYTES)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (soft_clr),
        .push_en (push_ok),
        .pkt     (pkt),
        .pop_en  (pop_ok),
        .pop_two (!narrow),
        .head_lo (head_lo),
        .head_hi (head_hi)
    );

    // R5
    mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_len < LEN_W'(FRAME_W)) |-> ((pop_data >> frm_len) == '0));

    // R10
    valid_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_valid && !narrow) |-> (fill_bytes >= CW'(2)));

endmodule

// File: tb/spi_tx_pack_fifo_tb.sv
`timescale 1ns/1ps
module spi_tx_pack_fifo_tb;

    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_clr = 1'b0;
    logic [4:0]  frm_len = 5'd8;
    logic        wr_en = 1'b0;
    logic        wr_half = 1'b0;
    logic [15:0] wr_data = '0;
    logic        pop_req = 1'b0;
    logic [15:0] pop_data;
    logic        pop_valid;
    logic        tx_empty;
    logic [2:0]  fill_bytes;
    logic        ovf;

    int n_cmp = 0;
    int n_bad = 0;
    int mfill = 0;
    bit finished = 1'b0;
    logic [15:0] expq [$];

    always #2 clk = ~clk;

    spi_tx_pack_fifo u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_clr   (soft_clr),
        .frm_len    (frm_len),
        .wr_en      (wr_en),
        .wr_half    (wr_half),
        .wr_data    (wr_data),
        .pop_req    (pop_req),
        .pop_data   (pop_data),
        .pop_valid  (pop_valid),
        .tx_empty   (tx_empty),
        .fill_bytes (fill_bytes),
        .ovf        (ovf)
    );

    function automatic logic [15:0] fmask(input int l);
        if (l >= 16) return 16'hFFFF;
        return 16'((32'd1 << l) - 1);
    endfunction

    function automatic bit is_narrow();
        return frm_len <= 5'd8;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Driver model update: uses fill before any pop of the same cycle (R11)
    task automatic model_write(input bit half, input logic [15:0] d);
        int need;
        need = is_narrow() ? (half ? 2 : 1) : 2;
        if (DEPTH - mfill >= need) begin
            if (is_narrow()) begin
                expq.push_back(16'(d[7:0]) & fmask(frm_len));
                if (half) expq.push_back(16'(d[15:8]) & fmask(frm_len));
            end else begin
                expq.push_back((half ? d : 16'(d[7:0])) & fmask(frm_len));
            end
            mfill += need;
        end
    endtask

    task automatic wr(input bit half, input logic [15:0] d);
        model_write(half, d);
        wr_en = 1'b1; wr_half = half; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_pop(input bit half, input logic [15:0] d);
        model_write(half, d);
        wr_en = 1'b1; wr_half = half; wr_data = d; pop_req = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; pop_req = 1'b0;
    endtask

    task automatic drain(input int n);
        repeat (n) begin
            pop_req = 1'b1;
            @(negedge clk);
        end
        pop_req = 1'b0;
    endtask

    // Monitor: compares popped frames with the scoreboard (R2 R3 R4 R5 R10)
    always @(negedge clk) begin
        int need;
        #1;
        if (rst_n && !soft_clr && pop_req) begin
            need = is_narrow() ? 1 : 2;
            check("R10 pop_valid", int'(pop_valid), int'(mfill >= need));
            if (pop_valid) begin
                if (expq.size() == 0) begin
                    check("R2 unexpected frame", int'(pop_data), -1);
                end else begin
                    check("R2/R3/R4/R5 frame", int'(pop_data), int'(expq.pop_front()));
                end
                mfill -= need;
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 fill", int'(fill_bytes), 0);
        check("R1 tx_empty", int'(tx_empty), 1);
        check("R1 pop_valid", int'(pop_valid), 0);
        check("R1 ovf", int'(ovf), 0);

        // R2 halfword packs two frames, low first
        frm_len = 5'd8;
        wr(1'b1, 16'h040A);
        check("R12 fill after half", int'(fill_bytes), 2);
        check("R6 tx_empty at half", int'(tx_empty), 1);
        check("R10 narrow valid", int'(pop_valid), 1);
        drain(2);
        check("R2 drained", int'(fill_bytes), 0);

        // R3 odd run ended with a byte write
        wr(1'b1, 16'h2211);
        wr(1'b0, 16'hEE33);
        check("R3 fill odd", int'(fill_bytes), 3);
        check("R6 tx_empty at 3", int'(tx_empty), 0);
        drain(3);
        check("R3 queue used", expq.size(), 0);

        // R5 narrow mask
        frm_len = 5'd5;
        wr(1'b1, 16'hFFFF);
        drain(2);

        // R7 overflow and drop
        frm_len = 5'd8;
        wr(1'b1, 16'hB2A1);
        wr(1'b0, 16'h00C3);
        wr(1'b1, 16'hFFEE);
        check("R7 dropped half fill", int'(fill_bytes), 3);
        check("R7 ovf set", int'(ovf), 1);
        wr(1'b0, 16'h00D4);
        check("R7 byte fits", int'(fill_bytes), 4);
        check("R6 full tx_empty", int'(tx_empty), 0);
        // R11 write plus pop while full: write judged on pre-pop count
        wr_pop(1'b0, 16'h0099);
        check("R11 full wr+pop", int'(fill_bytes), 3);
        check("R7 ovf sticky", int'(ovf), 1);
        drain(3);
        check("R7 nothing extra", expq.size(), 0);

        // R8 soft clear
        wr(1'b1, 16'h5566);
        soft_clr = 1'b1;
        @(negedge clk);
        soft_clr = 1'b0;
        expq.delete(); mfill = 0;
        check("R8 fill", int'(fill_bytes), 0);
        check("R8 ovf", int'(ovf), 0);
        check("R8 pop_valid", int'(pop_valid), 0);

        // R9 pop on empty ignored
        drain(2);
        check("R9 fill", int'(fill_bytes), 0);
        wr(1'b1, 16'h7708);
        // R11 write plus pop at fill 2
        wr_pop(1'b1, 16'h1A19);
        check("R11 fill", int'(fill_bytes), 3);
        drain(3);

        // R4 wide frames
        frm_len = 5'd12;
        wr(1'b1, 16'hABCD);
        check("R4 wide fill", int'(fill_bytes), 2);
        wr(1'b0, 16'hFF7F);
        check("R4 wide fill2", int'(fill_bytes), 4);
        wr(1'b1, 16'h1234);
        check("R7 wide drop", int'(ovf), 1);
        drain(2);
        frm_len = 5'd16;
        wr(1'b1, 16'hBEEF);
        drain(1);

        // R10 stray byte after widening
        frm_len = 5'd8;
        wr(1'b0, 16'h003C);
        frm_len = 5'd16;
        @(negedge clk);
        check("R10 half frame hidden", int'(pop_valid), 0);
        drain(1);
        check("R9 stray kept", int'(fill_bytes), 1);
        frm_len = 5'd8;
        drain(1);
        check("R12 final fill", int'(fill_bytes), 0);
        check("R2 scoreboard empty", expq.size(), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule